// File: doc/BRIEF.md
# Gray Timestamp Hit Buffer with Trigger Matching

This block is the end-of-column logic shared by a pair of pixel columns. It runs a free-running binary time counter and sends it out as an 8-bit Gray code to every pixel. When a pixel reports a hit, the block takes in the pixel number and the Gray times of the pulse's rising and falling edges. It stores them in one free slot of a pooled hit store.

Each trigger pulse becomes a requested time, which is the current time minus a programmable latency, and that time is queued in a small FIFO. The queued triggers are served one after another, in the order they arrived. For each trigger the controller visits every stored hit once and compares the binary-decoded leading-edge time with the requested time, modulo 256:
- A hit that matches is shifted out on a one-bit serial line and then freed.
- A hit that is older than the requested time is freed without being sent.
- A hit that is newer stays in the pool for a later trigger.

Every trigger's serial frame closes with an end-of-event marker, even when no hit matched.

Top module: `grayHitBuffer`

## Requirements
- R1: After reset the internal binary time counter starts at 0 and increases by one on each clock, wrapping modulo 256. It is presented on `tsGray` as `b ^ (b >> 1)`.
- R2: While reset is active and right after it, `serValid` is 0, `overflow` is 0, `tsGray` is 0 and the hit pool is empty.
- R3: A hit write (`hitWr` high for one clock) stores the pixel number and both Gray edge times in the lowest-numbered free slot. Up to DEPTH hits are held at once.
- R4: A hit write that arrives while all DEPTH slots are occupied is dropped. It also sets `overflow`, which then stays 1 until reset.
- R5: A trigger (`trigIn` high for one clock) queues the requested time T = (binary time at that clock − `latency`) mod 256. A trigger that arrives while TRIG_DEPTH triggers are already queued is ignored.
- R6: Queued triggers are served strictly in arrival order, and each one produces exactly one frame.
- R7: A stored hit whose decoded leading-edge time equals T is sent in that trigger's frame and is then removed.
- R8: A stored hit with (T − leading edge) mod 256 in 1..127 is removed without being sent. One with that difference in 128..255 is kept and can match a later trigger.
- R9: A hit record is 1 + PIX_W + 16 bits, sent MSB first while `serValid` is 1. It consists of a 1 start bit, then the pixel number, then the binary leading-edge time, then the binary trailing-edge time.
- R10: Every frame ends with an end-of-event marker of 9 bits: a 0, followed by T in binary, MSB first. The marker is sent even when the frame holds no hit record.
- R11: Within one frame, hit records leave in slot order. So hits written into an empty pool leave in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one bunch crossing per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| latency | input | TS_W | Trigger latency subtracted from the current time |
| hitWr | input | 1 | Hit write strobe |
| hitPix | input | PIX_W | Pixel number of the hit |
| hitLeGray | input | TS_W | Gray leading-edge time of the hit |
| hitTeGray | input | TS_W | Gray trailing-edge time of the hit |
| trigIn | input | 1 | Trigger pulse |
| tsGray | output | TS_W | Gray-coded time distributed to pixels |
| serOut | output | 1 | Serial data bit |
| serValid | output | 1 | High while `serOut` carries a frame bit |
| overflow | output | 1 | Sticky flag: a hit was lost to a full pool |

## Verification
The bench builds the block with an eight-slot pool, a 4-bit pixel number and a two-entry trigger FIFO. The 8-bit time width stays at its full size. With only eight slots the full-pool drop is reached in a handful of writes, and two queued triggers let a third, back-to-back trigger hit the full FIFO. The full 8-bit time lets the bench sweep all 256 distances between a hit's leading edge and the requested time. For each distance it checks whether the hit is sent, deleted or kept for a second trigger.

// File: rtl/ghbPkg.sv
package ghbPkg;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadRec;   // load record of scanned slot into shifter and free slot
    logic loadEoe;   // load end-of-event marker into shifter
    logic freeCur;   // free scanned slot without sending
    logic popTrig;   // retire head trigger
  } ghbStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_SEND,
    ST_EOE
  } ghbStateT;

endpackage

// File: rtl/ghbDatapath.sv
module ghbDatapath
  import ghbPkg::*;
#(
  parameter int TS_W       = 8,
  parameter int PIX_W      = 8,
  parameter int DEPTH      = 64,
  parameter int TRIG_DEPTH = 4,
  localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TS_W-1:0]  latency,
  input  logic             hitWr,
  input  logic [PIX_W-1:0] hitPix,
  input  logic [TS_W-1:0]  hitLeGray,
  input  logic [TS_W-1:0]  hitTeGray,
  input  logic             trigIn,
  input  ghbStrobeT        strobe,
  input  logic [IDX_W-1:0] scanIdx,
  output logic [TS_W-1:0]  tsGray,
  output logic             curValid,
  output logic             curMatch,
  output logic             curOlder,
  output logic             fifoEmpty,
  output logic             shBusy,
  output logic             serOut,
  output logic             serValid,
  output logic             overflow
);

  localparam int REC_LEN = 1 + PIX_W + 2 * TS_W;
  localparam int EOE_LEN = 1 + TS_W;
  localparam int CNT_W   = $clog2(REC_LEN + 1);
  localparam int TQ_AW   = (TRIG_DEPTH > 1) ? $clog2(TRIG_DEPTH) : 1;

  function automatic logic [TS_W-1:0] grayToBin(input logic [TS_W-1:0] g);
    logic [TS_W-1:0] b;
    b[TS_W-1] = g[TS_W-1];
    for (int i = TS_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- time counter ----------------
  logic [TS_W-1:0] tsBin;

  always_ff @(posedge clk) begin
    if (!rstN) tsBin <= '0;
    else       tsBin <= tsBin + 1'b1;
  end

  assign tsGray = tsBin ^ (tsBin >> 1);

  // ---------------- hit pool ----------------
  logic [DEPTH-1:0] slotValid;
  logic [PIX_W-1:0] slotPix [DEPTH];
  logic [TS_W-1:0]  slotLe  [DEPTH];
  logic [TS_W-1:0]  slotTe  [DEPTH];
  logic [IDX_W-1:0] freeIdx;
  logic             poolFull;
  logic             wrOk;
  logic             clrCur;

  always_comb begin
    freeIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!slotValid[i]) freeIdx = IDX_W'(i);
    end
  end

  assign poolFull = &slotValid;
  assign wrOk     = hitWr && !poolFull;
  assign clrCur   = strobe.loadRec || strobe.freeCur;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= '0;
    end else begin
      if (clrCur) slotValid[scanIdx] <= 1'b0;
      if (wrOk)   slotValid[freeIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wrOk) begin
      slotPix[freeIdx] <= hitPix;
      slotLe[freeIdx]  <= hitLeGray;
      slotTe[freeIdx]  <= hitTeGray;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                     overflow <= 1'b0;
    else if (hitWr && poolFull)    overflow <= 1'b1;
  end

  // ---------------- trigger queue ----------------
  logic [TS_W-1:0]  tqMem [TRIG_DEPTH];
  logic [TQ_AW-1:0] tqWr, tqRd;
  logic [TQ_AW:0]   tqCount;
  logic             tqPush, tqPop;
  logic [TS_W-1:0]  headT;

  assign tqPush    = trigIn && (tqCount != (TQ_AW+1)'(TRIG_DEPTH));
  assign tqPop     = strobe.popTrig;
  assign fifoEmpty = (tqCount == '0);
  assign headT     = tqMem[tqRd];

  function automatic logic [TQ_AW-1:0] nextPtr(input logic [TQ_AW-1:0] p);
    return (p == TQ_AW'(TRIG_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tqWr    <= '0;
      tqRd    <= '0;
      tqCount <= '0;
    end else begin
      if (tqPush) tqWr <= nextPtr(tqWr);
      if (tqPop)  tqRd <= nextPtr(tqRd);
      case ({tqPush, tqPop})
        2'b10:   tqCount <= tqCount + 1'b1;
        2'b01:   tqCount <= tqCount - 1'b1;
        default: tqCount <= tqCount;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (tqPush) tqMem[tqWr] <= tsBin - latency;
  end

  // ---------------- age compare on scanned slot ----------------
  logic [TS_W-1:0] curLeBin;
  logic [TS_W-1:0] age;

  assign curLeBin = grayToBin(slotLe[scanIdx]);
  assign age      = headT - curLeBin;
  assign curValid = slotValid[scanIdx];
  assign curMatch = (age == '0);
  assign curOlder = !age[TS_W-1] && (age != '0);

  // ---------------- serial shifter ----------------
  logic [REC_LEN-1:0] shReg;
  logic [CNT_W-1:0]   shCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      shCnt <= '0;
    end else if (strobe.loadRec) begin
      shReg <= {1'b1, slotPix[scanIdx], curLeBin, grayToBin(slotTe[scanIdx])};
      shCnt <= CNT_W'(REC_LEN);
    end else if (strobe.loadEoe) begin
      shReg <= {1'b0, headT, {(REC_LEN - EOE_LEN){1'b0}}};
      shCnt <= CNT_W'(EOE_LEN);
    end else if (shCnt != '0) begin
      shReg <= shReg << 1;
      shCnt <= shCnt - 1'b1;
    end
  end

  assign serOut   = shReg[REC_LEN-1];
  assign serValid = (shCnt != '0);
  assign shBusy   = serValid;

  // ---------------- assertions ----------------
  AST_TS_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> $countones(tsGray ^ $past(tsGray)) == 1);  // R1

  AST_FULL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    hitWr && poolFull |=> overflow);  // R4

  AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);  // R4

  AST_TQ_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    tqCount <= (TQ_AW+1)'(TRIG_DEPTH));  // R5

  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popTrig |-> !fifoEmpty);  // R6

  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadRec || strobe.loadEoe) |-> !shBusy);  // R9

  AST_REC_START_BIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadRec |=> serValid && serOut);  // R9

  AST_EOE_START_BIT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEoe |=> serValid && !serOut);  // R10

  AST_CLEAR_VALID_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    clrCur |-> curValid);  // R7

endmodule

// File: rtl/ghbControl.sv
module ghbControl
  import ghbPkg::*;
#(
  parameter int DEPTH  = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             curValid,
  input  logic             curMatch,
  input  logic             curOlder,
  input  logic             fifoEmpty,
  input  logic             shBusy,
  output ghbStrobeT        strobe,
  output logic [IDX_W-1:0] scanIdx
);

  ghbStateT state, nextState;
  logic     idxInc;
  logic     lastIdx;

  assign lastIdx = (scanIdx == IDX_W'(DEPTH - 1));

  always_comb begin
    strobe    = '0;
    nextState = state;
    idxInc    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (!fifoEmpty) nextState = ST_SCAN;
      end
      ST_SCAN: begin
        if (curValid && curMatch) begin
          strobe.loadRec = 1'b1;
          nextState      = ST_SEND;
        end else begin
          strobe.freeCur = curValid && curOlder;
          if (lastIdx) begin
            strobe.loadEoe = 1'b1;
            nextState      = ST_EOE;
          end else begin
            idxInc = 1'b1;
          end
        end
      end
      ST_SEND: begin
        if (!shBusy) begin
          if (lastIdx) begin
            strobe.loadEoe = 1'b1;
            nextState      = ST_EOE;
          end else begin
            idxInc    = 1'b1;
            nextState = ST_SCAN;
          end
        end
      end
      ST_EOE: begin
        if (!shBusy) begin
          strobe.popTrig = 1'b1;
          nextState      = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE) scanIdx <= '0;
      else if (idxInc)      scanIdx <= scanIdx + 1'b1;
    end
  end

  AST_ACTIVE_HAS_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    state != ST_IDLE |-> !fifoEmpty);  // R6

  AST_IDLE_LINE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_IDLE |-> !shBusy);  // R10

  AST_SCAN_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(state == ST_SCAN) && $past(state) == ST_IDLE |-> scanIdx == '0);  // R11

endmodule

// File: rtl/grayHitBuffer.sv
module grayHitBuffer
  import ghbPkg::*;
#(
  parameter int TS_W       = 8,
  parameter int PIX_W      = 8,
  parameter int DEPTH      = 64,
  parameter int TRIG_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TS_W-1:0]  latency,
  input  logic             hitWr,
  input  logic [PIX_W-1:0] hitPix,
  input  logic [TS_W-1:0]  hitLeGray,
  input  logic [TS_W-1:0]  hitTeGray,
  input  logic             trigIn,
  output logic [TS_W-1:0]  tsGray,
  output logic             serOut,
  output logic             serValid,
  output logic             overflow
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  ghbStrobeT        strobe;
  logic [IDX_W-1:0] scanIdx;
  logic             curValid, curMatch, curOlder, fifoEmpty, shBusy;

  ghbDatapath #(
    .TS_W(TS_W), .PIX_W(PIX_W), .DEPTH(DEPTH), .TRIG_DEPTH(TRIG_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .latency(latency),
    .hitWr(hitWr), .hitPix(hitPix), .hitLeGray(hitLeGray), .hitTeGray(hitTeGray),
    .trigIn(trigIn), .strobe(strobe), .scanIdx(scanIdx),
    .tsGray(tsGray), .curValid(curValid), .curMatch(curMatch), .curOlder(curOlder),
    .fifoEmpty(fifoEmpty), .shBusy(shBusy),
    .serOut(serOut), .serValid(serValid), .overflow(overflow)
  );

  ghbControl #(
    .DEPTH(DEPTH)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .curValid(curValid), .curMatch(curMatch), .curOlder(curOlder),
    .fifoEmpty(fifoEmpty), .shBusy(shBusy),
    .strobe(strobe), .scanIdx(scanIdx)
  );

  AST_SERIAL_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    serValid |-> !fifoEmpty);  // R10

endmodule

// File: tb/grayHitBuffer_tb.sv
module grayHitBuffer_tb;

  localparam int TS_W  = 8;
  localparam int PIX_W = 4;
  localparam int DEPTH = 8;
  localparam int TQD   = 2;
  localparam int LEN   = 1 + PIX_W + 2 * TS_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [TS_W-1:0]  latency = '0;
  logic             hitWr = 1'b0;
  logic [PIX_W-1:0] hitPix = '0;
  logic [TS_W-1:0]  hitLeGray = '0;
  logic [TS_W-1:0]  hitTeGray = '0;
  logic             trigIn = 1'b0;
  logic [TS_W-1:0]  tsGray;
  logic             serOut, serValid, overflow;

  always #5 clk = ~clk;

  grayHitBuffer #(.TS_W(TS_W), .PIX_W(PIX_W), .DEPTH(DEPTH), .TRIG_DEPTH(TQD)) u_dut (
    .clk(clk), .rstN(rstN), .latency(latency), .hitWr(hitWr), .hitPix(hitPix),
    .hitLeGray(hitLeGray), .hitTeGray(hitTeGray), .trigIn(trigIn),
    .tsGray(tsGray), .serOut(serOut), .serValid(serValid), .overflow(overflow)
  );

  int checks = 0;
  int errors = 0;

  function automatic int g2b(input int g);
    int b = 0;
    for (int i = 7; i >= 0; i--) b = b | ((((b >> (i + 1)) ^ (g >> i)) & 1) << i);
    return b;
  endfunction

  function automatic int b2g(input int b);
    return (b ^ (b >> 1)) & 255;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // serial decoder
  int rKind [64];
  int rPix  [64];
  int rLe   [64];
  int rTe   [64];
  int recN = 0;
  int eoeN = 0;
  int bitCnt = 0;
  int need = 0;
  logic [31:0] acc = '0;

  always @(negedge clk) begin
    if (!rstN) begin
      bitCnt = 0;
      acc = '0;
    end else if (serValid) begin
      if (bitCnt == 0) need = serOut ? LEN : 9;
      acc = {acc[30:0], serOut};
      bitCnt++;
      if (bitCnt == need) begin
        if (need == LEN) begin
          rKind[recN % 64] = 1;
          rPix[recN % 64]  = int'((acc >> 16) & 32'hF);
          rLe[recN % 64]   = int'((acc >> 8) & 32'hFF);
          rTe[recN % 64]   = int'(acc & 32'hFF);
        end else begin
          rKind[recN % 64] = 0;
          rLe[recN % 64]   = int'(acc & 32'hFF);
          eoeN++;
        end
        recN++;
        bitCnt = 0;
        acc = '0;
      end
    end
  end

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; hitWr = 1'b0; trigIn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeHit(input int pix, input int le, input int te);
    hitWr = 1'b1;
    hitPix = PIX_W'(pix);
    hitLeGray = TS_W'(b2g(le & 255));
    hitTeGray = TS_W'(b2g(te & 255));
    @(negedge clk);
    hitWr = 1'b0;
  endtask

  task automatic trigAt(input int t);
    latency = TS_W'((g2b(int'(tsGray)) - t) & 255);
    trigIn = 1'b1;
    @(negedge clk);
    trigIn = 1'b0;
  endtask

  task automatic waitEoe(input int target);
    while (eoeN < target) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expRec(input int idx, input int pix, input int le, input int te, input string req);
    chk(rKind[idx % 64] == 1, req, rKind[idx % 64], 1);
    chk(rPix[idx % 64] == pix, req, rPix[idx % 64], pix);
    chk(rLe[idx % 64] == (le & 255), req, rLe[idx % 64], le & 255);
    chk(rTe[idx % 64] == (te & 255), req, rTe[idx % 64], te & 255);
  endtask

  task automatic expEoe(input int idx, input int t, input string req);
    chk(rKind[idx % 64] == 0, req, rKind[idx % 64], 0);
    chk(rLe[idx % 64] == (t & 255), req, rLe[idx % 64], t & 255);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    // R2: reset state
    repeat (3) @(negedge clk);
    chk(tsGray == '0, "R2 tsGray", int'(tsGray), 0);
    chk(serValid == 1'b0, "R2 serValid", int'(serValid), 0);
    chk(overflow == 1'b0, "R2 overflow", int'(overflow), 0);
    rstN = 1'b1;

    // R1: counter sequence in Gray, across a wrap
    for (int c = 1; c <= 300; c++) begin
      @(negedge clk);
      chk(int'(tsGray) == b2g(c & 255), "R1 tsGray", int'(tsGray), b2g(c & 255));
    end

    // R2: empty pool after reset -> frame holds only the marker
    doReset();
    base = recN;
    trigAt(77);
    waitEoe(eoeN + 1);
    chk(recN - base == 1, "R2 empty pool", recN - base, 1);
    expEoe(base, 77, "R10 empty frame");

    // R3 R9 R11: records in write order, fields decoded
    doReset();
    for (int i = 0; i < 5; i++) writeHit(i + 1, 100, 100 + 2 * i + 3);
    base = recN;
    trigAt(100);
    waitEoe(eoeN + 1);
    chk(recN - base == 6, "R7 match count", recN - base, 6);
    for (int i = 0; i < 5; i++) expRec(base + i, i + 1, 100, 100 + 2 * i + 3, "R11 R9 record");
    expEoe(base + 5, 100, "R10 marker");

    // R4: full pool drops write and sets sticky flag
    doReset();
    for (int i = 0; i < DEPTH; i++) writeHit(i, 50, 60);
    chk(overflow == 1'b0, "R4 not yet full", int'(overflow), 0);
    writeHit(9, 50, 60);
    chk(overflow == 1'b1, "R4 overflow set", int'(overflow), 1);
    base = recN;
    trigAt(50);
    waitEoe(eoeN + 1);
    chk(recN - base == DEPTH + 1, "R4 dropped hit absent", recN - base, DEPTH + 1);
    for (int i = 0; i < DEPTH; i++) expRec(base + i, i, 50, 60, "R3 full pool");
    chk(overflow == 1'b1, "R4 sticky", int'(overflow), 1);

    // R5 R6: third back-to-back trigger meets a full queue
    doReset();
    base = eoeN;
    trigAt(10);
    trigAt(20);
    trigAt(30);
    repeat (300) @(negedge clk);
    chk(eoeN - base == 2, "R5 queue full drop", eoeN - base, 2);
    expEoe(recN - 2, 10, "R6 order first");
    expEoe(recN - 1, 20, "R6 order second");

    // R8: mixed ages
    doReset();
    writeHit(1, 200 - 5, 1);
    writeHit(2, 200, 2);
    writeHit(3, 203, 3);
    writeHit(4, 200, 4);
    writeHit(5, 200 - 127, 5);
    writeHit(6, 200 - 128, 6);
    base = recN;
    trigAt(200);
    waitEoe(eoeN + 1);
    chk(recN - base == 3, "R8 mixed first frame", recN - base, 3);
    expRec(base, 2, 200, 2, "R7 match");
    expRec(base + 1, 4, 200, 4, "R7 match");
    base = recN;
    trigAt(203);
    waitEoe(eoeN + 1);
    chk(recN - base == 2, "R8 newer kept", recN - base, 2);
    expRec(base, 3, 203, 3, "R8 newer");
    base = recN;
    trigAt(72);
    waitEoe(eoeN + 1);
    chk(recN - base == 2, "R8 age 128 kept", recN - base, 2);
    expRec(base, 6, 72, 6, "R8 boundary");
    base = recN;
    trigAt(195);
    waitEoe(eoeN + 1);
    chk(recN - base == 1, "R8 older gone", recN - base, 1);

    // R7 R8: sweep all 256 ages
    doReset();
    for (int a = 0; a < 256; a++) begin
      int tx, le, n1, n2;
      tx = (a * 37 + 11) & 255;
      le = (tx - a) & 255;
      writeHit(a & 15, le, le + 1);
      base = recN;
      trigAt(tx);
      waitEoe(eoeN + 1);
      n1 = (a == 0) ? 2 : 1;
      chk(recN - base == n1, "R7 R8 sweep first", recN - base, n1);
      if (a == 0) expRec(base, a & 15, le, le + 1, "R7 sweep record");
      base = recN;
      trigAt(le);
      waitEoe(eoeN + 1);
      n2 = (a >= 128) ? 2 : 1;
      chk(recN - base == n2, "R8 sweep second", recN - base, n2);
      if (a >= 128) expRec(base, a & 15, le, le + 1, "R8 sweep kept");
      expEoe(recN - 1, le, "R10 sweep marker");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule